// File: doc/BRIEF.md
# Interrupt Acceptance and Status Flag Update

This block decides whether a pending maskable interrupt request is taken, and keeps the processor status flag word in step with that decision. A hardware request is taken only when the interrupt-enable flag is set and the request's priority is strictly above the current processor priority level. When it is taken, the block masks further maskable interrupts and moves execution onto the interrupt stack. It also raises the level to the priority of the request.

A software interrupt strobe is always taken. It clears the enable flag. It switches to the interrupt stack only for low-numbered software interrupts. Each time an interrupt is taken, the block captures the flag word as it stood just before the update, so that a later stack push can store it. A restore input reloads the whole flag word in one cycle, for use by a return sequence, and it overrides any other event in that cycle.

Top module: `irq_accept_flags`

## Requirements
- R1: On synchronous reset all eleven flag bits, the saved word and the accept pulse are 0.
- R2: A hardware request (req_valid=1) is taken only when the enable flag (bit 6) is 1 and req_prio is strictly greater than the level field (bits 10:8). accept is then 1 with accept_sw=0 in the cycle after the edge that takes it.
- R3: When a hardware request is taken, the enable flag and the stack-select flag (bit 7) become 0 and the level field is loaded with req_prio. The flag bits 5:0 keep their values.
- R4: Whenever an interrupt of either kind is taken, saved_word takes on the flag word as it stood before that edge. saved_word holds its value at all other times.
- R5: A software strobe (swi_strobe=1) is taken whatever the enable flag and level are. It gives accept=1 with accept_sw=1, clears the enable flag, and leaves the level field and bits 5:0 unchanged.
- R6: A software interrupt with swi_num below 32 clears the stack-select flag. One with swi_num of 32 or more leaves it unchanged.
- R7: restore_valid=1 loads restore_word into the whole flag word at the next edge, takes no interrupt in that cycle, and leaves saved_word unchanged, even when a request or strobe is present.
- R8: When a hardware request that can be taken and a software strobe arrive in the same cycle, the hardware request is taken and the strobe is dropped.
- R9: A hardware request with priority not above the level, or one that arrives while the enable flag is 0, changes no flag and gives no accept.
- R10: In a cycle with no event taken and no restore, the flag word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Maskable hardware request pending |
| req_prio | input | 3 | Priority of the pending request |
| swi_strobe | input | 1 | Software interrupt instruction executing |
| swi_num | input | 6 | Software interrupt number |
| restore_valid | input | 1 | Reload the flag word |
| restore_word | input | 11 | Flag word to reload |
| accept | output | 1 | One-cycle pulse: an interrupt was taken |
| accept_sw | output | 1 | Qualifies accept: 1 for software, 0 for hardware |
| flag_word_o | output | 11 | Current flag word: carry 0, debug 1, zero 2, sign 3, bank 4, overflow 5, enable 6, stack select 7, level 10:8 |
| saved_word | output | 11 | Flag word captured at the last interrupt taken |

## Verification
On every cycle, the assertions check the following: the acceptance gate against the previous enable flag and level, the flag changes that follow each kind of take, that the saved word is captured at each take, that a restore lands and takes nothing, and that the flag word holds when no event occurs. Other behaviours can only be shown by the bench's scenarios. These are which event wins when a request, a strobe and a restore coincide, the boundary between equal and greater priority, and the split at software interrupt number 32. The bench shows them by driving these collisions and boundaries against its own model of the flag word.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    localparam int PRIO_W  = 3;
    localparam int FLAG_W  = 11;

    typedef struct packed {
        logic [PRIO_W-1:0] lvl;    // bits 10:8
        logic              stk;    // bit 7
        logic              ien;    // bit 6
        logic              ovf;    // bit 5
        logic              bank;   // bit 4
        logic              sign;   // bit 3
        logic              zero;   // bit 2
        logic              dbg;    // bit 1
        logic              carry;  // bit 0
    } flag_word_t;

    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_RESTORE = 2'd1,
        EV_HW      = 2'd2,
        EV_SW      = 2'd3
    } flag_event_e;

    function automatic logic ev_takes(flag_event_e ev);
        return (ev == EV_HW) || (ev == EV_SW);
    endfunction

    function automatic flag_word_t flags_after(
        flag_event_e       ev,
        flag_word_t        cur,
        logic [PRIO_W-1:0] prio,
        logic              sw_low,
        flag_word_t        reload
    );
        flag_word_t nxt;
        nxt = cur;
        unique case (ev)
            EV_RESTORE: nxt = reload;
            EV_HW: begin
                nxt.ien = 1'b0;
                nxt.stk = 1'b0;
                nxt.lvl = prio;
            end
            EV_SW: begin
                nxt.ien = 1'b0;
                if (sw_low) nxt.stk = 1'b0;
            end
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/irq_decide.sv
module irq_decide
    import irq_flag_pkg::*;
#(
    parameter int SWI_NUM_W     = 6,
    parameter int SWI_STK_LIMIT = 32
) (
    input  logic                 req_valid,
    input  logic [PRIO_W-1:0]    req_prio,
    input  logic                 swi_strobe,
    input  logic [SWI_NUM_W-1:0] swi_num,
    input  logic                 restore_valid,
    input  flag_word_t           cur,
    output flag_event_e          ev,
    output logic                 sw_low
);
    localparam logic [SWI_NUM_W:0] LIMIT = SWI_STK_LIMIT[SWI_NUM_W:0];

    logic hw_ok;

    always_comb begin
        hw_ok  = req_valid && cur.ien && (req_prio > cur.lvl);
        sw_low = ({1'b0, swi_num} < LIMIT);
        if (restore_valid)   ev = EV_RESTORE;
        else if (hw_ok)      ev = EV_HW;
        else if (swi_strobe) ev = EV_SW;
        else                 ev = EV_NONE;
    end
endmodule

// File: rtl/flag_state.sv
module flag_state
    import irq_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  flag_event_e       ev,
    input  logic [PRIO_W-1:0] prio,
    input  logic              sw_low,
    input  flag_word_t        reload,
    output flag_word_t        cur
);
    flag_word_t nxt;

    always_comb nxt = flags_after(ev, cur, prio, sw_low, reload);

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end
endmodule

// File: rtl/take_record.sv
module take_record
    import irq_flag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  flag_event_e ev,
    input  flag_word_t  cur,
    output logic        pulse,
    output logic        is_sw,
    output flag_word_t  saved
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
            is_sw <= 1'b0;
            saved <= '0;
        end else begin
            pulse <= ev_takes(ev);
            is_sw <= (ev == EV_SW);
            if (ev_takes(ev)) saved <= cur;
        end
    end
endmodule

// File: rtl/irq_accept_flags.sv
module irq_accept_flags
    import irq_flag_pkg::*;
#(
    parameter int SWI_NUM_W     = 6,
    parameter int SWI_STK_LIMIT = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [2:0]           req_prio,
    input  logic                 swi_strobe,
    input  logic [SWI_NUM_W-1:0] swi_num,
    input  logic                 restore_valid,
    input  logic [10:0]          restore_word,
    output logic                 accept,
    output logic                 accept_sw,
    output logic [10:0]          flag_word_o,
    output logic [10:0]          saved_word
);
    flag_word_t  cur;
    flag_word_t  saved;
    flag_event_e ev;
    logic        sw_low;

    irq_decide #(
        .SWI_NUM_W    (SWI_NUM_W),
        .SWI_STK_LIMIT(SWI_STK_LIMIT)
    ) u_decide (
        .req_valid    (req_valid),
        .req_prio     (req_prio),
        .swi_strobe   (swi_strobe),
        .swi_num      (swi_num),
        .restore_valid(restore_valid),
        .cur          (cur),
        .ev           (ev),
        .sw_low       (sw_low)
    );

    flag_state u_state (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .prio  (req_prio),
        .sw_low(sw_low),
        .reload(flag_word_t'(restore_word)),
        .cur   (cur)
    );

    take_record u_rec (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .cur  (cur),
        .pulse(accept),
        .is_sw(accept_sw),
        .saved(saved)
    );

    assign flag_word_o = cur;
    assign saved_word  = saved;
endmodule

// File: rtl/irq_accept_flags_chk.sv
module irq_accept_flags_chk #(
    parameter int SWI_NUM_W = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [2:0]           req_prio,
    input logic                 swi_strobe,
    input logic [SWI_NUM_W-1:0] swi_num,
    input logic                 restore_valid,
    input logic [10:0]          restore_word,
    input logic                 accept,
    input logic                 accept_sw,
    input logic [10:0]          flag_word_o,
    input logic [10:0]          saved_word
);
    assert_hw_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && !accept_sw) |-> ($past(flag_word_o[6]) && ($past(req_prio) > $past(flag_word_o[10:8]))));

    assert_hw_flags_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && !accept_sw) |-> (!flag_word_o[6] && !flag_word_o[7]
            && flag_word_o[10:8] == $past(req_prio) && flag_word_o[5:0] == $past(flag_word_o[5:0])));

    assert_saved_R4: assert property (@(posedge clk) disable iff (rst)
        accept |-> (saved_word == $past(flag_word_o)));

    assert_saved_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!accept && !$past(rst)) |-> $stable(saved_word));

    assert_sw_flags_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && accept_sw) |-> (!flag_word_o[6] && flag_word_o[10:8] == $past(flag_word_o[10:8])));

    assert_sw_high_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && accept_sw && ($past(swi_num) >= SWI_NUM_W'(32))) |-> (flag_word_o[7] == $past(flag_word_o[7])));

    assert_restore_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(restore_valid)) |-> (flag_word_o == $past(restore_word) && !accept));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !accept && !$past(restore_valid)) |-> $stable(flag_word_o));
endmodule

bind irq_accept_flags irq_accept_flags_chk #(.SWI_NUM_W(SWI_NUM_W)) u_chk (.*);

// File: tb/sim_irq_accept_flags.sv
`timescale 1ns/1ps
module sim_irq_accept_flags;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_prio = '0;
    logic        swi_strobe = 1'b0;
    logic [5:0]  swi_num = '0;
    logic        restore_valid = 1'b0;
    logic [10:0] restore_word = '0;
    logic        accept, accept_sw;
    logic [10:0] flag_word_o, saved_word;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic        acc;
        logic        sw;
        logic [10:0] flags;
        logic [10:0] saved;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [10:0] m_flags = '0;
    logic [10:0] m_saved = '0;

    always #2.5 clk = ~clk;

    irq_accept_flags u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_prio(req_prio),
        .swi_strobe(swi_strobe), .swi_num(swi_num),
        .restore_valid(restore_valid), .restore_word(restore_word),
        .accept(accept), .accept_sw(accept_sw),
        .flag_word_o(flag_word_o), .saved_word(saved_word)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected result.
    task automatic step(logic rq, logic [2:0] pr, logic sw, logic [5:0] num,
                        logic rs, logic [10:0] rw, string tag);
        exp_t e;
        @(negedge clk);
        req_valid = rq; req_prio = pr; swi_strobe = sw; swi_num = num;
        restore_valid = rs; restore_word = rw;
        e.acc = 1'b0; e.sw = 1'b0; e.tag = tag;
        if (rs) begin
            m_flags = rw;
        end else if (rq && m_flags[6] && (pr > m_flags[10:8])) begin
            e.acc = 1'b1;
            m_saved = m_flags;
            m_flags[6] = 1'b0;
            m_flags[7] = 1'b0;
            m_flags[10:8] = pr;
        end else if (sw) begin
            e.acc = 1'b1; e.sw = 1'b1;
            m_saved = m_flags;
            m_flags[6] = 1'b0;
            if (num < 6'd32) m_flags[7] = 1'b0;
        end
        e.flags = m_flags;
        e.saved = m_saved;
        q.push_back(e);
    endtask

    task automatic idle(string tag);
        step(1'b0, 3'd0, 1'b0, 6'd0, 1'b0, 11'd0, tag);
    endtask

    task automatic load(logic [10:0] w, string tag);
        step(1'b0, 3'd0, 1'b0, 6'd0, 1'b1, w, tag);
    endtask

    // Monitor: pops and compares once the edge has settled.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, {31'd0, accept}, {31'd0, e.acc}, "accept");
                if (e.acc) check(e.tag, {31'd0, accept_sw}, {31'd0, e.sw}, "accept_sw");
                check(e.tag, {21'd0, flag_word_o}, {21'd0, e.flags}, "flags");
                check(e.tag, {21'd0, saved_word}, {21'd0, e.saved}, "saved");
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", {21'd0, flag_word_o}, 32'd0, "reset flags");
        check("R1", {21'd0, saved_word},  32'd0, "reset saved");
        check("R1", {31'd0, accept},      32'd0, "reset accept");
        @(negedge clk);
        rst = 1'b0;

        idle("R10");
        step(1'b1, 3'd7, 1'b0, 6'd0, 1'b0, 11'd0, "R9");    // enable flag is 0
        load(11'b010_1_1_101010, "R7");                     // level 2, stk 1, ien 1
        idle("R10");
        step(1'b1, 3'd2, 1'b0, 6'd0, 1'b0, 11'd0, "R9");    // equal priority
        step(1'b1, 3'd1, 1'b0, 6'd0, 1'b0, 11'd0, "R9");    // lower priority
        step(1'b1, 3'd5, 1'b0, 6'd0, 1'b0, 11'd0, "R2");    // taken: R3, R4
        step(1'b1, 3'd7, 1'b0, 6'd0, 1'b0, 11'd0, "R9");    // masked after take
        idle("R4");
        load(11'b101_1_1_010101, "R7");
        step(1'b0, 3'd0, 1'b1, 6'd31, 1'b0, 11'd0, "R5");   // low number, clears stk (R6)
        load(11'b011_1_0_110011, "R7");                     // ien 0, stk 1
        step(1'b0, 3'd0, 1'b1, 6'd32, 1'b0, 11'd0, "R6");   // stk kept
        step(1'b0, 3'd0, 1'b1, 6'd63, 1'b0, 11'd0, "R6");
        step(1'b1, 3'd7, 1'b1, 6'd3, 1'b1, 11'b000_1_1_000001, "R7"); // restore wins
        step(1'b1, 3'd3, 1'b1, 6'd5, 1'b0, 11'd0, "R8");    // hw beats swi
        load(11'b110_0_1_111111, "R7");
        step(1'b1, 3'd7, 1'b0, 6'd0, 1'b0, 11'd0, "R2");    // 7 over 6
        idle("R10");
        idle("R10");

        repeat (3) @(posedge clk);
        #1;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule